// File: doc/BRIEF.md
# 8-bit ALU with Status Word

This block is the arithmetic core of an accumulator-based 8-bit controller, together with its program status word. The surrounding core presents an operation code, the accumulator, a second operand byte and the B register. The block returns the new accumulator value and the new B value on combinational outputs. When the core strobes the operation as executed, the block commits the resulting carry, auxiliary-carry and overflow flags into its status register on the next clock edge.

The status register also holds two register-bank select bits and two general-purpose flags. Software can write these bits through a write port. The parity bit is not stored: it always reflects the accumulator value presented at the input.

Status word layout: bit 7 carry (CY), bit 6 auxiliary carry (AC), bit 5 user flag 0, bits 4:3 bank select, bit 2 overflow (OV), bit 1 user flag 1, bit 0 parity.

Operation codes on `op_sel`: 0 pass, 1 ADD, 2 ADDC, 3 SUBB, 4 INC, 5 DEC, 6 DA, 7 MUL, 8 DIV.

Top module: `alu8_psw`

## Requirements
- R1: With op_sel=1 (ADD) acc_out is acc_in+opnd_in mod 256, ignoring the stored carry. With op_sel=2 (ADDC) acc_out is acc_in+opnd_in+CY mod 256. For both, an executed operation sets CY (bit 7) to the carry out of bit 7.
- R2: With op_sel=3 (SUBB) acc_out is acc_in−opnd_in−CY mod 256, and an executed operation sets CY to 1 exactly when a borrow out of bit 7 occurs.
- R3: For ADD, ADDC and SUBB, an executed operation sets AC (bit 6) to the carry (or, for SUBB, the borrow) out of bit 3.
- R4: For ADD, ADDC and SUBB, an executed operation sets OV (bit 2) exactly when the signed two's-complement result overflows.
- R5: op_sel=4 (INC) and op_sel=5 (DEC) give acc_in+1 and acc_in−1 modulo 256. op_sel=0 passes acc_in and b_in through unchanged. None of these three operations changes status bits 7:1. All operations other than MUL and DIV pass b_in to b_out.
- R6: op_sel=6 (DA) first adds 6 when the low nibble of acc_in exceeds 9 or AC is set. It then adds 0x60 when the high nibble of that intermediate value exceeds 9, when CY is set, or when the first step carried. An executed DA sets CY if a carry out of bit 7 occurs, never clears CY, and leaves AC and OV unchanged.
- R7: op_sel=7 (MUL) gives the low byte of acc_in×b_in on acc_out and the high byte on b_out. An executed MUL clears CY and sets OV exactly when the product exceeds 255.
- R8: op_sel=8 (DIV) with b_in≠0 gives the quotient acc_in/b_in on acc_out and the remainder on b_out. An executed DIV clears CY and OV.
- R9: DIV with b_in=0 gives acc_out=0xFF and b_out=acc_in. An executed divide by zero sets OV and clears CY.
- R10: Status bit 0 always equals the XOR of the eight bits of acc_in (1 for an odd count of ones). Writes to bit 0 have no effect.
- R11: psw_we loads psw_wdata[7:1] into status bits 7:1 on the next edge, with priority over a simultaneous op_valid. The bank select bits 4:3 and user flags keep their value across executed operations.
- R12: After reset, status bits 7:1 are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 4 | Operation code |
| op_valid | input | 1 | Operation executes this cycle; flags commit at the edge |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand byte |
| b_in | input | 8 | B register value |
| psw_we | input | 1 | Status write enable |
| psw_wdata | input | 8 | Status write data (bit 0 ignored) |
| acc_out | output | 8 | New accumulator value |
| b_out | output | 8 | New B register value |
| psw_out | output | 8 | Status word |

## Verification
The flag assertions assume that an operation's inputs are held stable through the edge on which op_valid commits it. They also assume that an operation counts as executed only when psw_we is low in that cycle. The bench follows this rule: it loads the prior flags with a status write in a cycle that has op_valid low, applies the operation in the next cycle, and drops op_valid afterwards. The divide identity assertion assumes b_in is nonzero. The bench covers the zero divisor separately, through the defined 0xFF/acc_in result.

// File: rtl/alu8_psw.sv
module alu8_psw (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] op_sel,
  input  logic       op_valid,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic [7:0] b_in,
  input  logic       psw_we,
  input  logic [7:0] psw_wdata,
  output logic [7:0] acc_out,
  output logic [7:0] b_out,
  output logic [7:0] psw_out
);
  localparam logic [3:0] OP_PASS = 4'd0, OP_ADD = 4'd1, OP_ADDC = 4'd2,
                         OP_SUBB = 4'd3, OP_INC = 4'd4, OP_DEC = 4'd5,
                         OP_DA = 4'd6, OP_MUL = 4'd7, OP_DIV = 4'd8;

  logic cy, ac, uf0, uf1, ov;
  logic [1:0] bank;
  logic n_cy, n_ac, n_ov;

  logic       cin;
  logic [8:0] sum9, dif9, da1, da2;
  logic [4:0] sum_lo, dif_lo;
  logic [15:0] prod;
  logic [7:0] quot, rmd;

  assign cin    = (op_sel == OP_ADDC) ? cy : 1'b0;
  assign sum9   = {1'b0, acc_in} + {1'b0, opnd_in} + {8'd0, cin};
  assign sum_lo = {1'b0, acc_in[3:0]} + {1'b0, opnd_in[3:0]} + {4'd0, cin};
  assign dif9   = {1'b0, acc_in} - {1'b0, opnd_in} - {8'd0, cy};
  assign dif_lo = {1'b0, acc_in[3:0]} - {1'b0, opnd_in[3:0]} - {4'd0, cy};
  assign prod   = {8'd0, acc_in} * {8'd0, b_in};
  assign quot   = (b_in != 8'd0) ? acc_in / b_in : 8'hFF;
  assign rmd    = (b_in != 8'd0) ? acc_in % b_in : acc_in;
  assign da1    = (acc_in[3:0] > 4'd9 || ac) ? {1'b0, acc_in} + 9'h006 : {1'b0, acc_in};
  assign da2    = (da1[7:4] > 4'd9 || cy || da1[8]) ? da1 + 9'h060 : da1;

  always_comb begin
    acc_out = acc_in;
    b_out   = b_in;
    n_cy    = cy;
    n_ac    = ac;
    n_ov    = ov;
    case (op_sel)
      OP_ADD, OP_ADDC: begin
        acc_out = sum9[7:0];
        n_cy    = sum9[8];
        n_ac    = sum_lo[4];
        n_ov    = (acc_in[7] == opnd_in[7]) && (sum9[7] != acc_in[7]);
      end
      OP_SUBB: begin
        acc_out = dif9[7:0];
        n_cy    = dif9[8];
        n_ac    = dif_lo[4];
        n_ov    = (acc_in[7] != opnd_in[7]) && (dif9[7] != acc_in[7]);
      end
      OP_INC: acc_out = acc_in + 8'd1;
      OP_DEC: acc_out = acc_in - 8'd1;
      OP_DA: begin
        acc_out = da2[7:0];
        n_cy    = cy | da2[8];
      end
      OP_MUL: begin
        acc_out = prod[7:0];
        b_out   = prod[15:8];
        n_cy    = 1'b0;
        n_ov    = (prod[15:8] != 8'd0);
      end
      OP_DIV: begin
        acc_out = quot;
        b_out   = rmd;
        n_cy    = 1'b0;
        n_ov    = (b_in == 8'd0);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cy, ac, uf0, bank, ov, uf1} <= 7'd0;
    end else if (psw_we) begin
      {cy, ac, uf0, bank, ov, uf1} <= psw_wdata[7:1];
    end else if (op_valid) begin
      cy <= n_cy;
      ac <= n_ac;
      ov <= n_ov;
    end
  end

  assign psw_out = {cy, ac, uf0, bank, ov, uf1, ^acc_in};

  a_r7_mul_clears_cy: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !psw_we && op_sel == OP_MUL |=> !psw_out[7]);

  a_r9_divzero_ov: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !psw_we && op_sel == OP_DIV && b_in == 8'd0 |=> psw_out[2] && !psw_out[7]);

  a_r8_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    op_sel == OP_DIV && b_in != 8'd0 |->
      ({8'd0, acc_out} * {8'd0, b_in} + {8'd0, b_out} == {8'd0, acc_in}) && (b_out < b_in));

  a_r5_incdec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !psw_we && (op_sel == OP_INC || op_sel == OP_DEC) |=> $stable(psw_out[7:1]));

  a_r11_write_load: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we |=> psw_out[7:1] == $past(psw_wdata[7:1]));

  a_r6_da_cy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !psw_we && op_sel == OP_DA && psw_out[7] |=> psw_out[7]);

  a_r11_bank_kept: assert property (@(posedge clk) disable iff (!rst_n)
    !psw_we |=> $stable(psw_out[4:3]));
endmodule

// File: tb/alu8_psw_tb.sv
`timescale 1ns/1ps
module alu8_psw_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] op_sel = '0;
  logic op_valid = 1'b0, psw_we = 1'b0;
  logic [7:0] acc_in = '0, opnd_in = '0, b_in = '0, psw_wdata = '0;
  logic [7:0] acc_out, b_out, psw_out;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alu8_psw dut_i (.clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_valid(op_valid),
    .acc_in(acc_in), .opnd_in(opnd_in), .b_in(b_in), .psw_we(psw_we),
    .psw_wdata(psw_wdata), .acc_out(acc_out), .b_out(b_out), .psw_out(psw_out));

  // op, a, opnd, b, prior {cy,ac,ov}, exp acc, exp b, exp {cy,ac,ov}
  localparam logic [49:0] VEC [15] = '{
    {4'd1, 8'h3C, 8'hC5, 8'h00, 3'b000, 8'h01, 8'h00, 3'b110},  // R1 R3 carry out
    {4'd2, 8'h7F, 8'h00, 8'h00, 3'b100, 8'h80, 8'h00, 3'b011},  // R1 R4 ADDC overflow
    {4'd1, 8'h12, 8'h34, 8'h55, 3'b100, 8'h46, 8'h55, 3'b000},  // R1 carry ignored
    {4'd3, 8'h80, 8'h01, 8'h00, 3'b000, 8'h7F, 8'h00, 3'b011},  // R2 R4 signed overflow
    {4'd3, 8'h10, 8'h20, 8'h00, 3'b100, 8'hEF, 8'h00, 3'b110},  // R2 R3 borrow
    {4'd4, 8'hFF, 8'h00, 8'h00, 3'b111, 8'h00, 8'h00, 3'b111},  // R5 INC wrap
    {4'd5, 8'h00, 8'h00, 8'h00, 3'b001, 8'hFF, 8'h00, 3'b001},  // R5 DEC wrap
    {4'd6, 8'hBD, 8'h00, 8'h00, 3'b000, 8'h23, 8'h00, 3'b100},  // R6 both nibbles
    {4'd6, 8'h81, 8'h00, 8'h00, 3'b111, 8'hE7, 8'h00, 3'b111},  // R6 flags force
    {4'd6, 8'h45, 8'h00, 8'h00, 3'b000, 8'h45, 8'h00, 3'b000},  // R6 no adjust
    {4'd7, 8'h50, 8'h00, 8'hA0, 3'b110, 8'h00, 8'h32, 3'b011},  // R7 large product
    {4'd7, 8'h0F, 8'h00, 8'h11, 3'b101, 8'hFF, 8'h00, 3'b000},  // R7 exactly 255
    {4'd8, 8'hFB, 8'h00, 8'h12, 3'b111, 8'h0D, 8'h11, 3'b010},  // R8 divide
    {4'd8, 8'h37, 8'h00, 8'h00, 3'b100, 8'hFF, 8'h37, 3'b001},  // R9 divide by zero
    {4'd0, 8'h5A, 8'h00, 8'h77, 3'b101, 8'h5A, 8'h77, 3'b101}   // R5 pass
  };

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic run_vec(logic [49:0] v);
    @(negedge clk);
    op_valid = 1'b0; psw_we = 1'b1;
    psw_wdata = {v[21], v[20], 3'b000, v[19], 2'b00};
    @(negedge clk);
    psw_we = 1'b0;
    op_sel = v[49:46]; acc_in = v[45:38]; opnd_in = v[37:30]; b_in = v[29:22];
    op_valid = 1'b1;
    #1;
    chk("R1/R2/R5/R6/R7/R8/R9 acc_out", {8'd0, acc_out}, {8'd0, v[18:11]});
    chk("R5/R7/R8/R9 b_out", {8'd0, b_out}, {8'd0, v[10:3]});
    chk("R10 parity", {15'd0, psw_out[0]}, {15'd0, ^v[45:38]});
    @(negedge clk);
    op_valid = 1'b0;
    chk("R1/R2/R3/R4/R6/R7/R8/R9 flags cy,ac,ov",
        {13'd0, psw_out[7], psw_out[6], psw_out[2]}, {13'd0, v[2:0]});
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=completion");
      finish_run();
    end
  end

  initial begin
    #12 rst_n = 1'b1;
    @(negedge clk);
    chk("R12 reset status", {8'd0, psw_out}, 16'h0000);

    foreach (VEC[i]) run_vec(VEC[i]);

    // R10: write to bit 0 ignored, parity follows acc_in
    @(negedge clk);
    acc_in = 8'h00; psw_we = 1'b1; psw_wdata = 8'h01;
    @(negedge clk);
    psw_we = 1'b0;
    chk("R10 parity not writable", {15'd0, psw_out[0]}, 16'h0000);
    acc_in = 8'h07; #1;
    chk("R10 parity odd ones", {15'd0, psw_out[0]}, 16'h0001);

    // R11: write beats op, banks and user flags retained across ops
    @(negedge clk);
    acc_in = 8'h00; psw_we = 1'b1; psw_wdata = 8'h3A;
    op_sel = 4'd1; opnd_in = 8'h00; op_valid = 1'b1;
    @(negedge clk);
    psw_we = 1'b0;
    chk("R11 write priority", {8'd0, psw_out}, 16'h003A);
    acc_in = 8'hFF; opnd_in = 8'hFF; op_sel = 4'd1;
    @(negedge clk);
    op_valid = 1'b0; acc_in = 8'h00;
    #1;
    chk("R11 banks kept", {8'd0, psw_out}, 16'h00FA);

    done = 1'b1;
    finish_run();
  end
endmodule